// File: doc/BRIEF.md
# Microcontroller Data Register Space with I/O Ports

This block holds the 8-bit data register space of a small microcontroller, addresses 00h to 1Fh. It holds the status flags and a pointer register for indirect access. It keeps the output latches and the write-only direction controls of two bidirectional ports, and 25 bytes of general-purpose RAM. The core drives one read address and one write address each cycle. The read result is combinational. A write takes effect on the next rising clock edge.

The ALU feeds its carry, half-carry and zero results in through per-flag enables. The program counter's low byte is shown through a read-only view. A write to that location is passed out on a strobe, and the sequencer owns the counter itself. Each port exposes pin input, output and output-enable vectors. The pad side handles pull resistors and open-drain drive.

Address 00h is a window. A read or write there reaches the location named by the pointer at 04h. Bits that are not stored return fixed values.

Top module: `sfr_regfile`

## Requirements
- R1: Location 01h is unimplemented. It always reads 00h, and writes to it change nothing that can be read.
- R2: Locations 07h to 1Fh are 25 general-purpose bytes. A write is readable after the next rising edge, and bytes at other locations keep their values.
- R3: Reading or writing 00h acts on the location whose address is held in the low five bits of the pointer register at 04h.
- R4: When the pointer holds 00h, reading 00h returns 00h. A write to 00h changes no location, and it does not pulse the program-counter write strobe.
- R5: STATUS at 03h holds carry in bit 0, half carry in bit 1, zero in bit 2, power-loss in bit 3, page select in bit 5 and free bits 6 and 7. Bit 4 always reads 1. After reset it reads 18h.
- R6: The ALU updates carry, half carry and zero through separate enables, written on the next edge. In the same cycle as a STATUS write, an enabled flag overrides the written bit.
- R7: The pointer at 04h stores five bits. Bits 7 to 5 read as 1, so after reset it reads E0h.
- R8: Reading port A at 05h returns its four pins in bits 3..0, 1s in bits 6..4 and 0 in bit 7. Port B at 06h uses all eight bits.
- R9: Each port has a direction register that cannot be read back. Bit value 1 means input (output-enable low) and 0 means output (output-enable high). Both reset to all ones. They are loaded from the write data when the direction strobe is high, and port select 0 picks port A and 1 picks port B.
- R10: A port read returns the pin level for bits in input mode and the output latch for bits in output mode. The latches reset to 0 and drive the pin outputs.
- R11: Reading 02h returns the program-counter low-byte input. A write to 02h, direct or through the window, raises the PC write strobe in the same cycle with the data on the PC write-data output.
- R12: The page-select output follows STATUS bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr | input | 5 | Read address |
| rd_data | output | 8 | Combinational read data |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Write address |
| wr_data | input | 8 | Write data, also used for direction loads |
| dir_we | input | 1 | Direction register write strobe |
| dir_sel | input | 1 | Direction target: 0 port A, 1 port B |
| flag_we | input | 3 | Enables for zero, half carry, carry (bits 2..0) |
| flag_val | input | 3 | ALU flag values, same bit order |
| pc_lo_in | input | 8 | Program counter low byte for reading |
| pc_wr | output | 1 | Write to the PC location this cycle |
| pc_wdata | output | 8 | Data for the PC write |
| page_sel | output | 1 | STATUS page select bit |
| pa_in | input | 4 | Port A pin levels |
| pa_out | output | 4 | Port A output latch |
| pa_oe | output | 4 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |

## Verification
Reads, including pin levels seen through a port, have no latency. The bench sets the address and samples one nanosecond later, away from any edge. Stored values, direction changes and flag updates land on the first rising edge after the request. Each write is therefore held across one full cycle from a falling edge, and its result is read after the following falling edge. The PC write strobe is due in the same cycle as the request, so it is sampled while the write is still driven and again after it is removed.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
   localparam int A_WINDOW = 0;
   localparam int A_NONE   = 1;
   localparam int A_PCL    = 2;
   localparam int A_STATUS = 3;
   localparam int A_PTR    = 4;
   localparam int A_PORTA  = 5;
   localparam int A_PORTB  = 6;
   localparam int A_RAM0   = 7;

   localparam int ST_C    = 0;
   localparam int ST_HC   = 1;
   localparam int ST_Z    = 2;
   localparam int ST_ONE  = 4;
   localparam int ST_PAGE = 5;
   localparam int NFLAGS  = 3;

   localparam logic [7:0] STATUS_RST = 8'h18;
endpackage

// File: rtl/sfr_port.sv
module sfr_port #(
   parameter int W = 8,
   parameter int DW = 8,
   parameter logic [DW-1:0] FILL = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          lat_we,
   input  logic          dir_we,
   input  logic [DW-1:0] wdata,
   input  logic [W-1:0]  pin_in,
   output logic [W-1:0]  pin_out,
   output logic [W-1:0]  pin_oe,
   output logic [DW-1:0] rdata
);
   if (W < 1 || W > DW) begin : g_bad_w
      $error("sfr_port: W out of range");
   end

   logic [W-1:0] lat_q, dir_q, mix;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_q <= '0;
         dir_q <= '1;
      end else begin
         if (lat_we) lat_q <= wdata[W-1:0];
         if (dir_we) dir_q <= wdata[W-1:0];
      end
   end

   assign pin_out = lat_q;
   assign pin_oe  = ~dir_q;
   assign mix     = (dir_q & pin_in) | (~dir_q & lat_q);

   if (W < DW) begin : g_pad
      assign rdata = {FILL[DW-1:W], mix};
   end else begin : g_full
      assign rdata = mix;
   end

   p_dir_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      dir_we |=> pin_oe == ~$past(wdata[W-1:0]));
   p_latch_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
      lat_we |=> pin_out == $past(wdata[W-1:0]));
   p_latch_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !lat_we |=> $stable(pin_out));
endmodule

// File: rtl/sfr_status.sv
module sfr_status
   import sfr_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DW-1:0]     wdata,
   input  logic [NFLAGS-1:0] flag_we,
   input  logic [NFLAGS-1:0] flag_val,
   output logic [DW-1:0]     status
);
   if (DW != 8) begin : g_bad_dw
      $error("sfr_status: DW must be 8");
   end

   logic [DW-1:0] st_q, st_d;

   always_comb begin
      st_d = we ? wdata : st_q;
      for (int i = 0; i < NFLAGS; i++) begin
         if (flag_we[i]) st_d[i] = flag_val[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= STATUS_RST;
      else        st_q <= st_d;
   end

   always_comb begin
      status = st_q;
      status[ST_ONE] = 1'b1;
   end

   for (genvar g = 0; g < NFLAGS; g++) begin : g_flag_chk
      p_flag_upd_r6: assert property (@(posedge clk) disable iff (!rst_n)
         flag_we[g] |=> status[g] == $past(flag_val[g]));
   end
   p_bit4_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> status[ST_ONE]);
endmodule

// File: rtl/sfr_gpr.sv
module sfr_gpr #(
   parameter int DW = 8,
   parameter int AW = 5,
   parameter int BASE = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = (1 << AW) - BASE;

   if (DEPTH < 1) begin : g_bad_depth
      $error("sfr_gpr: no room for RAM");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] widx, ridx;
   logic          w_in, r_in;

   assign widx = waddr - AW'(BASE);
   assign ridx = raddr - AW'(BASE);
   assign w_in = waddr >= AW'(BASE);
   assign r_in = raddr >= AW'(BASE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (we && w_in) begin
         mem[widx] <= wdata;
      end
   end

   assign rdata = r_in ? mem[ridx] : '0;

   p_ram_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (we && w_in) |=> mem[$past(widx)] == $past(wdata));
endmodule

// File: rtl/sfr_regfile.sv
module sfr_regfile
   import sfr_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 5,
   parameter int PA_W = 4,
   parameter int PB_W = 8,
   parameter logic [7:0] PA_FILL = 8'h70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     rd_addr,
   output logic [DW-1:0]     rd_data,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic              dir_we,
   input  logic              dir_sel,
   input  logic [NFLAGS-1:0] flag_we,
   input  logic [NFLAGS-1:0] flag_val,
   input  logic [DW-1:0]     pc_lo_in,
   output logic              pc_wr,
   output logic [DW-1:0]     pc_wdata,
   output logic              page_sel,
   input  logic [PA_W-1:0]   pa_in,
   output logic [PA_W-1:0]   pa_out,
   output logic [PA_W-1:0]   pa_oe,
   input  logic [PB_W-1:0]   pb_in,
   output logic [PB_W-1:0]   pb_out,
   output logic [PB_W-1:0]   pb_oe
);
   localparam int PTR_PAD = DW - AW;

   if (DW != 8) begin : g_bad_dw
      $error("sfr_regfile: DW must be 8");
   end
   if (AW < 3 || AW >= DW) begin : g_bad_aw
      $error("sfr_regfile: AW out of range");
   end

   logic [AW-1:0] ptr_q, rd_eff, wr_eff;
   logic          wr_null;
   logic [DW-1:0] status, pa_rd, pb_rd, ram_rd;

   assign rd_eff  = (rd_addr == AW'(A_WINDOW)) ? ptr_q : rd_addr;
   assign wr_eff  = (wr_addr == AW'(A_WINDOW)) ? ptr_q : wr_addr;
   assign wr_null = wr_eff == AW'(A_WINDOW);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                ptr_q <= '0;
      else if (wr_en && wr_eff == AW'(A_PTR))    ptr_q <= wr_data[AW-1:0];
   end

   assign pc_wr    = wr_en && wr_eff == AW'(A_PCL);
   assign pc_wdata = wr_data;

   sfr_status #(.DW(DW)) u_status (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && wr_eff == AW'(A_STATUS)),
      .wdata(wr_data), .flag_we(flag_we), .flag_val(flag_val),
      .status(status)
   );
   assign page_sel = status[ST_PAGE];

   sfr_port #(.W(PA_W), .DW(DW), .FILL(PA_FILL)) u_pa (
      .clk(clk), .rst_n(rst_n),
      .lat_we(wr_en && wr_eff == AW'(A_PORTA)),
      .dir_we(dir_we && !dir_sel),
      .wdata(wr_data), .pin_in(pa_in),
      .pin_out(pa_out), .pin_oe(pa_oe), .rdata(pa_rd)
   );

   sfr_port #(.W(PB_W), .DW(DW), .FILL('0)) u_pb (
      .clk(clk), .rst_n(rst_n),
      .lat_we(wr_en && wr_eff == AW'(A_PORTB)),
      .dir_we(dir_we && dir_sel),
      .wdata(wr_data), .pin_in(pb_in),
      .pin_out(pb_out), .pin_oe(pb_oe), .rdata(pb_rd)
   );

   sfr_gpr #(.DW(DW), .AW(AW), .BASE(A_RAM0)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .we(wr_en && !wr_null),
      .waddr(wr_eff), .wdata(wr_data),
      .raddr(rd_eff), .rdata(ram_rd)
   );

   always_comb begin
      case (rd_eff)
         AW'(A_WINDOW): rd_data = '0;
         AW'(A_NONE):   rd_data = '0;
         AW'(A_PCL):    rd_data = pc_lo_in;
         AW'(A_STATUS): rd_data = status;
         AW'(A_PTR):    rd_data = {{PTR_PAD{1'b1}}, ptr_q};
         AW'(A_PORTA):  rd_data = pa_rd;
         AW'(A_PORTB):  rd_data = pb_rd;
         default:       rd_data = ram_rd;
      endcase
   end

   p_unimpl_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr == AW'(A_NONE) |-> rd_data == '0);
   p_null_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(A_WINDOW) && ptr_q == '0)
      |=> $stable(status) && $stable(ptr_q) && $stable(pa_out) && $stable(pb_out));
   p_null_no_pc_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(A_WINDOW) && ptr_q == '0) |-> !pc_wr);
   p_ptr_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_addr == AW'(A_PTR) |-> rd_data[DW-1:AW] == '1);
   p_page_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == AW'(A_STATUS) && flag_we == '0) |=> page_sel == $past(wr_data[ST_PAGE]));
endmodule

// File: tb/tb_sfr_regfile.sv
module tb_sfr_regfile;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] rd_addr = '0, wr_addr = '0;
   logic [7:0] rd_data, wr_data = '0, pc_lo_in = 8'h3C, pc_wdata;
   logic       wr_en = 1'b0, dir_we = 1'b0, dir_sel = 1'b0, pc_wr, page_sel;
   logic [2:0] flag_we = '0, flag_val = '0;
   logic [3:0] pa_in = 4'h5, pa_out, pa_oe;
   logic [7:0] pb_in = 8'h3C, pb_out, pb_oe;
   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   sfr_regfile dut (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .dir_we(dir_we), .dir_sel(dir_sel), .flag_we(flag_we), .flag_val(flag_val),
      .pc_lo_in(pc_lo_in), .pc_wr(pc_wr), .pc_wdata(pc_wdata), .page_sel(page_sel),
      .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
      .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe)
   );

   task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %02h expected %02h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic dwr(input logic sel, input logic [7:0] d);
      @(negedge clk); dir_we = 1'b1; dir_sel = sel; wr_data = d;
      @(negedge clk); dir_we = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] v);
      rd_addr = a; #1; v = rd_data;
   endtask

   task automatic t_reset;
      logic [7:0] v;
      rd(5'h03, v); chk("R5 status reset", v, 8'h18);
      chk("R12 page reset", {7'd0, page_sel}, 8'h00);
      rd(5'h04, v); chk("R7 pointer reset", v, 8'hE0);
      chk("R9 pa_oe reset", {4'd0, pa_oe}, 8'h00);
      chk("R9 pb_oe reset", pb_oe, 8'h00);
      rd(5'h05, v); chk("R8 port A input read", v, 8'h75);
      rd(5'h06, v); chk("R10 port B input read", v, 8'h3C);
   endtask

   task automatic t_unimpl;
      logic [7:0] v;
      wr(5'h01, 8'hFF);
      rd(5'h01, v); chk("R1 unimplemented", v, 8'h00);
   endtask

   task automatic t_ram;
      logic [7:0] v;
      wr(5'h07, 8'hA1); wr(5'h1F, 8'h5B); wr(5'h12, 8'hC3);
      rd(5'h07, v); chk("R2 ram low", v, 8'hA1);
      rd(5'h1F, v); chk("R2 ram high", v, 8'h5B);
      rd(5'h12, v); chk("R2 ram mid", v, 8'hC3);
      rd(5'h08, v); chk("R2 neighbour kept", v, 8'h00);
   endtask

   task automatic t_window;
      logic [7:0] v;
      wr(5'h04, 8'h10);
      rd(5'h04, v); chk("R7 pointer upper ones", v, 8'hF0);
      wr(5'h00, 8'h5E);
      rd(5'h10, v); chk("R3 indirect write", v, 8'h5E);
      rd(5'h00, v); chk("R3 indirect read", v, 8'h5E);
      wr(5'h04, 8'h07);
      rd(5'h00, v); chk("R3 indirect read ram0", v, 8'hA1);
   endtask

   task automatic t_null;
      logic [7:0] v;
      wr(5'h04, 8'h00);
      @(negedge clk); wr_en = 1'b1; wr_addr = 5'h00; wr_data = 8'h77;
      #1; chk("R4 no pc strobe", {7'd0, pc_wr}, 8'h00);
      @(negedge clk); wr_en = 1'b0;
      rd(5'h00, v); chk("R4 null read", v, 8'h00);
      rd(5'h03, v); chk("R4 status untouched", v, 8'h18);
      rd(5'h04, v); chk("R4 pointer untouched", v, 8'hE0);
      rd(5'h07, v); chk("R4 ram untouched", v, 8'hA1);
      chk("R4 latches untouched", {pa_out, 4'd0} | pb_out, 8'h00);
   endtask

   task automatic t_status;
      logic [7:0] v;
      wr(5'h03, 8'h00);
      rd(5'h03, v); chk("R5 bit4 stays set", v, 8'h10);
      wr(5'h03, 8'hE7);
      rd(5'h03, v); chk("R5 writable bits", v, 8'hF7);
      chk("R12 page follows", {7'd0, page_sel}, 8'h01);
      @(negedge clk); wr_en = 1'b1; wr_addr = 5'h03; wr_data = 8'h00;
      flag_we = 3'b101; flag_val = 3'b001;
      @(negedge clk); wr_en = 1'b0; flag_we = '0;
      rd(5'h03, v); chk("R6 flag over write", v, 8'h11);
      @(negedge clk); flag_we = 3'b010; flag_val = 3'b010;
      @(negedge clk); flag_we = '0;
      rd(5'h03, v); chk("R6 half carry only", v, 8'h13);
      chk("R12 page cleared", {7'd0, page_sel}, 8'h00);
   endtask

   task automatic t_ports;
      logic [7:0] v;
      wr(5'h06, 8'hA5);
      dwr(1'b1, 8'h0F);
      chk("R9 pb_oe mixed", pb_oe, 8'hF0);
      chk("R10 pb_out latch", pb_out, 8'hA5);
      rd(5'h06, v); chk("R10 port B mix", v, 8'hAC);
      chk("R9 pa_oe unchanged", {4'd0, pa_oe}, 8'h00);
      wr(5'h05, 8'hFA);
      dwr(1'b0, 8'h00);
      chk("R9 pa_oe all out", {4'd0, pa_oe}, 8'h0F);
      rd(5'h05, v); chk("R8 port A output read", v, 8'h7A);
      pb_in = 8'hC3; rd(5'h06, v); chk("R10 pin change", v, 8'hA3);
   endtask

   task automatic t_pc;
      logic [7:0] v;
      @(negedge clk); wr_en = 1'b1; wr_addr = 5'h02; wr_data = 8'h9A;
      #1; chk("R11 pc strobe", {7'd0, pc_wr}, 8'h01);
      chk("R11 pc data", pc_wdata, 8'h9A);
      @(negedge clk); wr_en = 1'b0;
      #1; chk("R11 strobe drops", {7'd0, pc_wr}, 8'h00);
      rd(5'h02, v); chk("R11 pc view", v, 8'h3C);
      wr(5'h04, 8'h02);
      @(negedge clk); wr_en = 1'b1; wr_addr = 5'h00; wr_data = 8'h44;
      #1; chk("R11 indirect strobe", {7'd0, pc_wr}, 8'h01);
      @(negedge clk); wr_en = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_unimpl();
      t_ram();
      t_window();
      t_null();
      t_status();
      t_ports();
      t_pc();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule